// File: doc/BRIEF.md
# Three-Channel Fan PWM Controller

This block drives three fan pulse-width-modulated outputs from a small bank of byte registers. Software reaches the registers through an address/data pair inside a byte-wide I/O window: the register number is written at window offset 5 and the register contents are then read or written at window offset 6. One shared mode register enables the individual channels, picks one of eight prescaled timebase rates, turns on a minimum-duty clamp and sets the output polarity for all pins. A second shared register holds per-channel smart-mode and tachometer-enable bits. These bits are stored and read back only.

All channels share one 8-bit period counter, so a period is always 256 prescaled ticks. Channel 1 runs at a duty value fixed by a parameter. Channels 2 and 3 each have a duty register, a mode register and an auto-mode register. In software mode the duty register is applied at the next period boundary. In automatic mode the channel either holds the duty it already has or, with smoothing enabled, moves it one count per period toward the duty register. No temperature curve and no tachometer measurement are part of the block.

Top module: `fpwm_ctrl`

## Requirements
- R1: Writing window offset 5 loads the register index. Writing offset 6 writes the indexed register and leaves the index unchanged. Reading offset 6 returns the indexed register and reading offset 5 returns the index. Any unmapped index reads as 0x00. The mapped indices are 0x13, 0x14, 0x16, 0x17, 0x6B, 0x6C, 0x73 and 0x74.
- R2: In register 0x14, bit n-1 enables channel n (n = 1..3). A disabled channel holds its pin at the inactive level.
- R3: Bits 6:4 of register 0x14 select the tick divisor from the main clock: 0→1, 1→2, 2→4, 3→6, 4→8, 5→16, 6→32, 7→SLOW_DIV (default 936).
- R4: Bit 7 of register 0x14 sets the polarity. 1 means the active level is high; 0 means the active level is low.
- R5: A period is 256 ticks. An enabled channel is active for exactly its applied duty count of ticks per period, so duty 0x00 is never active and duty 0xFF is active for 255 ticks.
- R6: A new duty value takes effect only at a period boundary, so the period already running keeps its old pulse length.
- R7: With bit 3 of register 0x14 set, any applied duty below MIN_DUTY (default 0x10) is output as MIN_DUTY.
- R8: Register 0x13 stores smart-mode bits (bit n-1) and tachometer-enable bits (bit n+3), reads them back, and has no effect on the outputs.
- R9: Bit 7 of register 0x16 (channel 2) or 0x17 (channel 3) selects automatic mode when set. In automatic mode with smoothing off, the applied duty holds and duty register writes are not applied.
- R10: Bit 7 of register 0x6C (channel 2) or 0x74 (channel 3) enables smoothing. In automatic mode the applied duty then moves by one count per period toward the duty register, 0x6B (channel 2) or 0x73 (channel 3).
- R11: Channel 1 always runs in software mode with the duty value CH1_DUTY (default 0x80).
- R12: After reset every register reads 0x00 and all three pins sit high, which is the inactive level for low polarity with all channels disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_off | input | 3 | Byte offset within the I/O window |
| io_wr | input | 1 | Write strobe for io_off/io_wdata |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_off (combinational) |
| fan_pwm | output | 3 | PWM pins, bit n-1 is channel n |

## Verification
A register write lands on the clock edge that samples the strobe, and a read is combinational, so register checks sample in the low phase right after the access. A duty or mode change reaches a pin only at the next period boundary, up to 256 ticks later. Duty checks therefore wait out more than one full period and then count active cycles over exactly one period, which gives a count independent of phase, or they time pulse lengths from rising edge to falling edge after syncing to a period start. Smoothing and boundary checks sync to a period start before each write, so every later pulse length is known period by period.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int CNT_W = 8;

  localparam logic [7:0] A_MAIN  = 8'h13;
  localparam logic [7:0] A_MODE  = 8'h14;
  localparam logic [7:0] A_CM2   = 8'h16;
  localparam logic [7:0] A_CM3   = 8'h17;
  localparam logic [7:0] A_DUTY2 = 8'h6B;
  localparam logic [7:0] A_AUTO2 = 8'h6C;
  localparam logic [7:0] A_DUTY3 = 8'h73;
  localparam logic [7:0] A_AUTO3 = 8'h74;

  function automatic int unsigned clk_div(input logic [2:0] sel, input int unsigned slow);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 16;
      3'd6:    return 32;
      default: return slow;
    endcase
  endfunction
endpackage

// File: rtl/fpwm_regs.sv
module fpwm_regs #(
  parameter int OFF_W   = 3,
  parameter int IDX_OFF = 5,
  parameter int DAT_OFF = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] io_off,
  input  logic             io_wr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic [7:0]       mode_q,
  output logic [7:0]       main_q,
  output logic [1:0][7:0]  cmode_q,
  output logic [1:0][7:0]  duty_q,
  output logic [1:0][7:0]  auto_q
);
  import fpwm_pkg::*;

  logic [7:0]      idx_q, idx_d, mode_d, main_d;
  logic [1:0][7:0] cmode_d, duty_d, auto_d;
  logic            idx_we, dat_we;

  assign idx_we = io_wr && (io_off == OFF_W'(IDX_OFF));
  assign dat_we = io_wr && (io_off == OFF_W'(DAT_OFF));

  always_comb begin
    idx_d   = idx_q;
    mode_d  = mode_q;
    main_d  = main_q;
    cmode_d = cmode_q;
    duty_d  = duty_q;
    auto_d  = auto_q;
    if (idx_we) idx_d = io_wdata;
    if (dat_we) begin
      case (idx_q)
        A_MAIN:  main_d     = io_wdata;
        A_MODE:  mode_d     = io_wdata;
        A_CM2:   cmode_d[0] = io_wdata;
        A_CM3:   cmode_d[1] = io_wdata;
        A_DUTY2: duty_d[0]  = io_wdata;
        A_AUTO2: auto_d[0]  = io_wdata;
        A_DUTY3: duty_d[1]  = io_wdata;
        A_AUTO3: auto_d[1]  = io_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      mode_q  <= '0;
      main_q  <= '0;
      cmode_q <= '0;
      duty_q  <= '0;
      auto_q  <= '0;
    end else begin
      idx_q   <= idx_d;
      mode_q  <= mode_d;
      main_q  <= main_d;
      cmode_q <= cmode_d;
      duty_q  <= duty_d;
      auto_q  <= auto_d;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_off == OFF_W'(IDX_OFF)) io_rdata = idx_q;
    else if (io_off == OFF_W'(DAT_OFF)) begin
      case (idx_q)
        A_MAIN:  io_rdata = main_q;
        A_MODE:  io_rdata = mode_q;
        A_CM2:   io_rdata = cmode_q[0];
        A_CM3:   io_rdata = cmode_q[1];
        A_DUTY2: io_rdata = duty_q[0];
        A_AUTO2: io_rdata = auto_q[0];
        A_DUTY3: io_rdata = duty_q[1];
        A_AUTO3: io_rdata = auto_q[1];
        default: io_rdata = '0;
      endcase
    end
  end

  // R1: a data-port write never disturbs the index
  p_idx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_off != OFF_W'(IDX_OFF)) |=> $stable(idx_q));
endmodule

// File: rtl/fpwm_timebase.sv
module fpwm_timebase #(
  parameter int unsigned SLOW_DIV = 936
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 clk_sel,
  output logic [fpwm_pkg::CNT_W-1:0] cnt_q,
  output logic                       wrap
);
  import fpwm_pkg::*;

  localparam int DIV_W = ($clog2(SLOW_DIV + 1) > 6) ? $clog2(SLOW_DIV + 1) : 6;

  logic [DIV_W-1:0] div_q, div_d, lim;
  logic [CNT_W-1:0] cnt_d;
  logic             tick;

  always_comb begin
    lim   = DIV_W'(clk_div(clk_sel, SLOW_DIV) - 1);
    tick  = (div_q >= lim);
    div_d = tick ? '0 : div_q + 1'b1;
    cnt_d = tick ? cnt_q + 1'b1 : cnt_q;
    wrap  = tick && (cnt_q == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: the period counter moves only on a prescaled tick
  p_cnt_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R3: the prescaler never runs past the largest divisor
  p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_q < DIV_W'(SLOW_DIV > 32 ? SLOW_DIV : 32));
endmodule

// File: rtl/fpwm_chan.sv
module fpwm_chan #(
  parameter logic [7:0] MIN_DUTY = 8'h10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wrap,
  input  logic [fpwm_pkg::CNT_W-1:0] cnt,
  input  logic                       en,
  input  logic                       pol_high,
  input  logic                       min_on,
  input  logic                       auto_mode,
  input  logic                       smooth,
  input  logic [7:0]                 duty_reg,
  output logic                       pwm
);
  logic [7:0] applied_q, applied_d, eff;
  logic       act;

  always_comb begin
    applied_d = applied_q;
    if (wrap) begin
      if (!auto_mode)                       applied_d = duty_reg;
      else if (smooth && applied_q < duty_reg) applied_d = applied_q + 8'd1;
      else if (smooth && applied_q > duty_reg) applied_d = applied_q - 8'd1;
    end
    eff = (min_on && applied_q < MIN_DUTY) ? MIN_DUTY : applied_q;
    act = en && (cnt < eff);
    pwm = pol_high ? act : !act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) applied_q <= '0;
    else        applied_q <= applied_d;
  end

  // R6: the applied duty changes only at a period boundary
  p_duty_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(applied_q));
  // R10: a smoothed step is exactly one count
  p_smooth_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && auto_mode && smooth && applied_q != duty_reg) |=>
    (applied_q == $past(applied_q) + 8'd1 || applied_q == $past(applied_q) - 8'd1));
  // R9: automatic mode without smoothing holds the duty
  p_auto_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !smooth) |=> $stable(applied_q));
endmodule

// File: rtl/fpwm_ctrl.sv
module fpwm_ctrl #(
  parameter int unsigned SLOW_DIV = 936,
  parameter logic [7:0]  MIN_DUTY = 8'h10,
  parameter logic [7:0]  CH1_DUTY = 8'h80,
  parameter int          IDX_OFF  = 5,
  parameter int          DAT_OFF  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] io_off,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic [2:0] fan_pwm
);
  import fpwm_pkg::*;

  localparam int NCH = 3;

  logic [7:0]       mode_q, main_q;
  logic [1:0][7:0]  cmode_q, duty_q, auto_q;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  fpwm_regs #(.OFF_W(3), .IDX_OFF(IDX_OFF), .DAT_OFF(DAT_OFF)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mode_q(mode_q),
    .main_q(main_q), .cmode_q(cmode_q), .duty_q(duty_q), .auto_q(auto_q)
  );

  fpwm_timebase #(.SLOW_DIV(SLOW_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .clk_sel(mode_q[6:4]), .cnt_q(cnt), .wrap(wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic       am, sm;
    logic [7:0] dr;
    if (c == 0) begin : g_fixed
      assign am = 1'b0;
      assign sm = 1'b0;
      assign dr = CH1_DUTY;
    end else begin : g_prog
      assign am = cmode_q[c-1][7];
      assign sm = auto_q[c-1][7];
      assign dr = duty_q[c-1];
    end
    fpwm_chan #(.MIN_DUTY(MIN_DUTY)) u_ch (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt(cnt),
      .en(mode_q[c]), .pol_high(mode_q[7]), .min_on(mode_q[3]),
      .auto_mode(am), .smooth(sm), .duty_reg(dr), .pwm(fan_pwm[c])
    );
  end

  // R8: smart/tach bits are storage only; main_q feeds no output logic
  p_main_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q) && !wrap |=> $stable(fan_pwm) || $changed(cnt) || $past(wrap));
endmodule

// File: tb/sim_fpwm_ctrl.sv
module sim_fpwm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] io_off = '0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [2:0] fan_pwm;
  int         n_chk = 0, n_bad = 0;
  longint     cyc = 0;

  localparam int SLOW = 10;

  fpwm_ctrl #(.SLOW_DIV(SLOW), .MIN_DUTY(8'h10), .CH1_DUTY(8'h80)) u0 (
    .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .fan_pwm(fan_pwm)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mode(input logic [2:0] en, input logic mn,
                                      input logic [2:0] sel, input logic pol);
    return {pol, sel, mn, en};
  endfunction

  function automatic int divof(input int sel);
    int t[8] = '{1, 2, 4, 6, 8, 16, 32, SLOW};
    return t[sel];
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); io_wr = 1'b1; io_off = 3'd5; io_wdata = a;
    @(negedge clk); io_off = 3'd6; io_wdata = v;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); io_wr = 1'b1; io_off = 3'd5; io_wdata = a;
    @(negedge clk); io_wr = 1'b0; io_off = 3'd6;
    #1 v = io_rdata;
  endtask

  task automatic count_act(input int ch, input logic pol, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fan_pwm[ch] == pol) c++;
    end
  endtask

  task automatic wait_rise(input int ch, output longint t0);
    logic prev;
    @(negedge clk); prev = fan_pwm[ch];
    forever begin
      @(negedge clk);
      if (!prev && fan_pwm[ch]) break;
      prev = fan_pwm[ch];
    end
    t0 = cyc;
  endtask

  task automatic wait_fall(input int ch);
    while (fan_pwm[ch]) @(negedge clk);
  endtask

  task automatic meas_run(input int ch, output longint len);
    longint t0;
    wait_rise(ch, t0);
    wait_fall(ch);
    len = cyc - t0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int c;
    longint len, t0;
    int duties[6] = '{0, 1, 8'h40, 8'h80, 8'hFE, 8'hFF};

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 pins after reset", fan_pwm, 3'b111);
    rst_n = 1'b1;
    rd_reg(8'h14, v); chk("R12 mode reset", v, 0);
    rd_reg(8'h6B, v); chk("R12 duty2 reset", v, 0);

    // R1 register access
    wr_reg(8'h6B, 8'h5A);
    rd_reg(8'h6B, v); chk("R1 duty2 readback", v, 8'h5A);
    @(negedge clk); io_off = 3'd5; #1 chk("R1 index readback", io_rdata, 8'h6B);
    rd_reg(8'h50, v); chk("R1 unmapped reads zero", v, 0);
    wr_reg(8'h50, 8'hEE);
    rd_reg(8'h6B, v); chk("R1 unmapped write harmless", v, 8'h5A);

    // R3 divisor sweep, ch2 duty 0x5A, high polarity
    for (int s = 0; s < 8; s++) begin
      wr_reg(8'h14, mode(3'b010, 1'b0, 3'(s), 1'b1));
      repeat (256 * divof(s) + 40) @(negedge clk);
      count_act(1, 1'b1, 256 * divof(s), c);
      chk($sformatf("R3 sel %0d active count", s), c, 8'h5A * divof(s));
    end

    // R5 duty sweep at divisor 1
    wr_reg(8'h14, mode(3'b010, 1'b0, 3'd0, 1'b1));
    foreach (duties[i]) begin
      wr_reg(8'h6B, 8'(duties[i]));
      repeat (300) @(negedge clk);
      count_act(1, 1'b1, 256, c);
      chk($sformatf("R5 duty %0d", duties[i]), c, duties[i]);
    end

    // R4 low polarity: active level is low
    wr_reg(8'h6B, 8'h30);
    wr_reg(8'h14, mode(3'b010, 1'b0, 3'd0, 1'b0));
    repeat (300) @(negedge clk);
    count_act(1, 1'b0, 256, c);
    chk("R4 low-polarity active count", c, 8'h30);

    // R2 disabled channels sit inactive
    count_act(2, 1'b0, 256, c);
    chk("R2 disabled ch3 never active", c, 0);
    wr_reg(8'h14, mode(3'b000, 1'b0, 3'd0, 1'b1));
    repeat (4) @(negedge clk);
    count_act(1, 1'b1, 256, c);
    chk("R2 disabled ch2 never active", c, 0);

    // R11 channel 1 fixed duty
    wr_reg(8'h14, mode(3'b001, 1'b0, 3'd0, 1'b1));
    repeat (300) @(negedge clk);
    count_act(0, 1'b1, 256, c);
    chk("R11 ch1 fixed duty", c, 8'h80);

    // R7 minimum duty clamp
    wr_reg(8'h6B, 8'h04);
    wr_reg(8'h14, mode(3'b010, 1'b1, 3'd0, 1'b1));
    repeat (300) @(negedge clk);
    count_act(1, 1'b1, 256, c);
    chk("R7 clamp raises 4 to 16", c, 16);
    wr_reg(8'h6B, 8'h20);
    repeat (300) @(negedge clk);
    count_act(1, 1'b1, 256, c);
    chk("R7 clamp leaves 32", c, 32);

    // R8 main register stored, inert
    wr_reg(8'h13, 8'h77);
    rd_reg(8'h13, v); chk("R8 main readback", v, 8'h77);
    repeat (300) @(negedge clk);
    count_act(1, 1'b1, 256, c);
    chk("R8 output unaffected", c, 32);

    // R6 boundary: mid-period write keeps current pulse
    wr_reg(8'h14, mode(3'b110, 1'b0, 3'd0, 1'b1));
    wr_reg(8'h6B, 8'h80);
    repeat (300) @(negedge clk);
    wait_rise(1, t0);
    repeat (4) @(negedge clk);
    wr_reg(8'h6B, 8'h20);
    wait_fall(1);
    chk("R6 current pulse keeps old duty", cyc - t0, 8'h80);
    meas_run(1, len);
    chk("R6 next pulse has new duty", len, 8'h20);

    // R10 smoothing on channel 3
    wr_reg(8'h73, 8'h40);
    repeat (300) @(negedge clk);
    wr_reg(8'h17, 8'h80);
    wr_reg(8'h74, 8'h80);
    wait_rise(2, t0);
    repeat (4) @(negedge clk);
    wr_reg(8'h73, 8'h44);
    for (int k = 1; k <= 5; k++) begin
      meas_run(2, len);
      chk($sformatf("R10 smooth up step %0d", k), len, (k < 4) ? 8'h40 + k : 8'h44);
    end
    wait_rise(2, t0);
    repeat (4) @(negedge clk);
    wr_reg(8'h73, 8'h42);
    for (int k = 1; k <= 3; k++) begin
      meas_run(2, len);
      chk($sformatf("R10 smooth down step %0d", k), len, (k < 2) ? 8'h43 : 8'h42);
    end

    // R9 automatic hold without smoothing
    wr_reg(8'h74, 8'h00);
    wr_reg(8'h73, 8'h10);
    wait_rise(2, t0);
    meas_run(2, len);
    chk("R9 auto hold", len, 8'h42);
    wait_rise(2, t0);
    repeat (4) @(negedge clk);
    wr_reg(8'h17, 8'h00);
    meas_run(2, len);
    chk("R9 back to software applies duty", len, 8'h10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule